// File: doc/BRIEF.md
# Packed Byte Dot-Product Accumulator

This block is a vector datapath for integer inference kernels. Each operand vector is cut into groups of four bytes. Inside a group, each byte of the first operand is multiplied by the byte in the same position of the second operand. The four products are added to the matching 32-bit accumulator lane, and the block returns one 32-bit result per lane. The lane count is a parameter: four lanes form a 128-bit vector and eight lanes form a 256-bit vector.

A two-bit select sets how the operand bytes are read. The choices are both signed, first signed with second unsigned, or both unsigned. A separate enable picks saturating or wrapping arithmetic for the final sum. The saturating form clamps to the signed 32-bit range in the two signed modes. In the unsigned mode it clamps to the unsigned 32-bit ceiling, and the accumulator is read as unsigned. The result is registered: one cycle after an input strobe, the result and a valid flag appear at the outputs.

Top module: `pbdp_acc`

## Requirements
- R1: Result lane j is built from bytes 4j to 4j+3 of both operands, paired by position, and from accumulator bits [32j+31:32j]. A zero byte contributes nothing, whatever its partner byte is.
- R2: With `sgn_sel` = 2'b00, both bytes are read as two's-complement values. For example, 0xFF times 0x05 contributes -5.
- R3: With `sgn_sel` = 2'b01, the `opa` byte is read as signed and the `opb` byte as unsigned, and the product is signed. For example, 0xFF times 0xFF contributes -255.
- R4: With `sgn_sel` = 2'b10, both bytes are read as unsigned. For example, 0xFF times 0xFF contributes +65025, never a negative value.
- R5: With `sat_en` = 0, each lane result is the exact sum taken modulo 2^32, in every mode.
- R6: With `sat_en` = 1 and `sgn_sel` 2'b00 or 2'b01, a sum above 0x7FFFFFFF gives 0x7FFFFFFF and a sum below -2^31 gives 0x80000000. A sum inside that range is returned unchanged.
- R7: With `sat_en` = 1 and `sgn_sel` = 2'b10, the accumulator lane is read as unsigned. A sum above 2^32-1 gives 0xFFFFFFFF, so the result is never below the accumulator lane. For example, 0x7FFFFFFF plus 4 gives 0x80000003.
- R8: When `in_vld` is sampled high at a clock edge, `out_data` carries that input's result and `out_vld` is 1 after the edge. When `in_vld` is low, `out_vld` is 0 after the edge and `out_data` holds its value. Back-to-back strobes give one result per cycle.
- R9: While reset is active, `out_vld` is 0 and `out_data` is all zeros. Reset asserts asynchronously. It is released through a two-stage synchronizer.
- R10: The select code 2'b11 behaves exactly like 2'b00, with both operands signed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input strobe; the operands are captured at this edge |
| sgn_sel | input | 2 | Signedness select: 00 both signed, 01 signed×unsigned, 10 both unsigned, 11 same as 00 |
| sat_en | input | 1 | 1 = saturate the final sum, 0 = wrap |
| opa | input | LANES*32 | First byte operand vector |
| opb | input | LANES*32 | Second byte operand vector |
| acc_in | input | LANES*32 | Accumulator lanes |
| out_vld | output | 1 | Result valid, one cycle after `in_vld` |
| out_data | output | LANES*32 | Registered result lanes |

## Verification
The bench sets one operand pattern against each select code, so that a wrong extension changes the result. If the 0xFF byte were sign-extended in unsigned mode, 0xFF times 0xFF would come out as +4 instead of +260100 per lane. If the `opb` byte were sign-extended in the mixed mode, the result would come out as +4 instead of -1020. It also drives sums just past each saturation bound, in both directions, with saturation on and then off. If the clamp were computed from a 32-bit sum, it would wrap instead of clamping. If the unsigned mode used the signed clamp, 0x7FFFFFFF plus 4 would stick at 0x7FFFFFFF. Lane-distinct and byte-position patterns expose swapped lanes or bytes. Idle cycles between strobes with changing inputs expose an output register that does not hold its value.

// File: rtl/dp_pkg.sv
package dp_pkg;
  // Operand signedness select codes
  typedef enum logic [1:0] {
    SEL_SS  = 2'b00,
    SEL_SU  = 2'b01,
    SEL_UU  = 2'b10,
    SEL_ALT = 2'b11
  } sgn_sel_e;

  // Bytes that feed one 32-bit lane
  localparam int unsigned GRP = 4;
endpackage

// File: rtl/dp_rst_sync.sv
module dp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  // Assert asynchronously, release after two clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dp_sat.sv
module dp_sat #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned SUM_W = 35
) (
  input  logic [SUM_W-1:0] sum,
  input  logic             sat_en,
  input  logic             uns,
  output logic [ACC_W-1:0] res
);
  logic neg, s_hi, s_lo, u_hi;

  always_comb begin
    neg  = sum[SUM_W-1];
    // Signed range holds when bits above ACC_W-1 all match the sign bit
    s_hi = !neg && (sum[SUM_W-2:ACC_W-1] != '0);
    s_lo =  neg && (sum[SUM_W-2:ACC_W-1] != '1);
    // Unsigned range holds when nothing sits above bit ACC_W-1
    u_hi = !neg && (sum[SUM_W-2:ACC_W] != '0);

    if (!sat_en) begin
      res = sum[ACC_W-1:0];
    end else if (uns) begin
      if (u_hi)     res = '1;
      else if (neg) res = '0;
      else          res = sum[ACC_W-1:0];
    end else begin
      if (s_hi)      res = {1'b0, {(ACC_W-1){1'b1}}};
      else if (s_lo) res = {1'b1, {(ACC_W-1){1'b0}}};
      else           res = sum[ACC_W-1:0];
    end
  end
endmodule

// File: rtl/dp_lane.sv
module dp_lane
  import dp_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ACC_W  = 32
) (
  input  logic [GRP*BYTE_W-1:0] a_grp,
  input  logic [GRP*BYTE_W-1:0] b_grp,
  input  logic [ACC_W-1:0]      acc,
  input  logic                  a_sgn,
  input  logic                  b_sgn,
  input  logic                  acc_uns,
  input  logic                  sat_en,
  output logic [ACC_W-1:0]      res
);
  localparam int unsigned EXT_W  = BYTE_W + 1;
  localparam int unsigned PROD_W = 2 * EXT_W;
  // Room for an unsigned accumulator, the sign and the grown product sum
  localparam int unsigned SUM_W  = ACC_W + 3;

  logic signed [PROD_W-1:0] prod [GRP];
  logic        [SUM_W-1:0]  sum;

  for (genvar g = 0; g < GRP; g++) begin : g_mul
    logic signed [EXT_W-1:0] ax, bx;
    assign ax = $signed({a_sgn & a_grp[g*BYTE_W+BYTE_W-1], a_grp[g*BYTE_W +: BYTE_W]});
    assign bx = $signed({b_sgn & b_grp[g*BYTE_W+BYTE_W-1], b_grp[g*BYTE_W +: BYTE_W]});
    assign prod[g] = ax * bx;
  end

  always_comb begin
    if (acc_uns) sum = {{(SUM_W-ACC_W){1'b0}}, acc};
    else         sum = {{(SUM_W-ACC_W){acc[ACC_W-1]}}, acc};
    for (int i = 0; i < GRP; i++) begin
      sum = sum + {{(SUM_W-PROD_W){prod[i][PROD_W-1]}}, prod[i]};
    end
  end

  dp_sat #(.ACC_W(ACC_W), .SUM_W(SUM_W)) u_sat (
    .sum    (sum),
    .sat_en (sat_en),
    .uns    (acc_uns),
    .res    (res)
  );
endmodule

// File: rtl/pbdp_acc.sv
module pbdp_acc
  import dp_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ACC_W  = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_vld,
  input  logic [1:0]                  sgn_sel,
  input  logic                        sat_en,
  input  logic [LANES*GRP*BYTE_W-1:0] opa,
  input  logic [LANES*GRP*BYTE_W-1:0] opb,
  input  logic [LANES*ACC_W-1:0]      acc_in,
  output logic                        out_vld,
  output logic [LANES*ACC_W-1:0]      out_data
);
  localparam int unsigned GRP_W = GRP * BYTE_W;
  localparam int unsigned OUT_W = LANES * ACC_W;

  logic             rst_sync_n;
  logic             a_sgn, b_sgn, acc_uns;
  logic [OUT_W-1:0] lane_res;
  logic [OUT_W-1:0] data_d, data_q;
  logic             vld_d, vld_q;
  sgn_sel_e         sel;

  dp_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Mode decode
  always_comb begin
    sel     = sgn_sel_e'(sgn_sel);
    a_sgn   = (sel != SEL_UU);
    b_sgn   = (sel == SEL_SS) || (sel == SEL_ALT);
    acc_uns = (sel == SEL_UU);
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    dp_lane #(.BYTE_W(BYTE_W), .ACC_W(ACC_W)) u_lane (
      .a_grp   (opa[j*GRP_W +: GRP_W]),
      .b_grp   (opb[j*GRP_W +: GRP_W]),
      .acc     (acc_in[j*ACC_W +: ACC_W]),
      .a_sgn   (a_sgn),
      .b_sgn   (b_sgn),
      .acc_uns (acc_uns),
      .sat_en  (sat_en),
      .res     (lane_res[j*ACC_W +: ACC_W])
    );
  end

  // Next state: capture on strobe, hold otherwise
  always_comb begin
    vld_d  = in_vld;
    data_d = in_vld ? lane_res : data_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_d;
      data_q <= data_d;
    end
  end

  assign out_vld  = vld_q;
  assign out_data = data_q;
endmodule

// File: rtl/pbdp_acc_chk.sv
module pbdp_acc_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ACC_W  = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_vld,
  input logic [1:0]                sgn_sel,
  input logic                      sat_en,
  input logic [LANES*4*BYTE_W-1:0] opa,
  input logic [LANES*4*BYTE_W-1:0] opb,
  input logic [LANES*ACC_W-1:0]    acc_in,
  input logic                      out_vld,
  input logic [LANES*ACC_W-1:0]    out_data
);
  // R8: a strobe is followed by a valid result
  a_r8_vld_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  // R8: no strobe, no valid
  a_r8_idle_no_vld: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);

  // R8: data holds across idle cycles
  a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(out_data));

  // R1: with a zero first operand every lane passes its accumulator through
  a_r1_zero_ops_pass_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && opa == '0 && opb != '1) |=> (out_data == $past(acc_in)));

  // R9: held clear while reset is active
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r9_reset_clear: assert (out_vld == 1'b0 && out_data == '0);
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane_chk
    // R7: unsigned saturating result never drops below the accumulator lane
    a_r7_uu_sat_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && sat_en && sgn_sel == 2'b10) |=>
        (out_data[j*ACC_W +: ACC_W] >= $past(acc_in[j*ACC_W +: ACC_W])));
  end
endmodule

bind pbdp_acc pbdp_acc_chk #(.LANES(LANES), .BYTE_W(BYTE_W), .ACC_W(ACC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .in_vld   (in_vld),
  .sgn_sel  (sgn_sel),
  .sat_en   (sat_en),
  .opa      (opa),
  .opb      (opb),
  .acc_in   (acc_in),
  .out_vld  (out_vld),
  .out_data (out_data)
);

// File: tb/tb_pbdp_acc.sv
module tb_pbdp_acc;
  localparam int L = 4;
  localparam int W = L * 32;

  typedef struct packed {
    logic [3:0]   req;
    logic [1:0]   sel;
    logic         sat;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] acc;
    logic [W-1:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    // R2: 2*3 per byte, acc 10
    '{4'd2,  2'b00, 1'b0, {16{8'h02}}, {16{8'h03}}, {4{32'd10}}, {4{32'h00000022}}},
    // R2: -1*5 per byte, acc 100
    '{4'd2,  2'b00, 1'b0, {16{8'hFF}}, {16{8'h05}}, {4{32'd100}}, {4{32'h00000050}}},
    // R3: -1*255 per byte
    '{4'd3,  2'b01, 1'b0, {16{8'hFF}}, {16{8'hFF}}, {4{32'd0}}, {4{32'hFFFFFC04}}},
    // R4: 255*255 per byte
    '{4'd4,  2'b10, 1'b0, {16{8'hFF}}, {16{8'hFF}}, {4{32'd0}}, {4{32'h0003F804}}},
    // R5: signed wrap past max
    '{4'd5,  2'b00, 1'b0, {16{8'h01}}, {16{8'h01}}, {4{32'h7FFFFFFF}}, {4{32'h80000003}}},
    // R6: signed clamp high
    '{4'd6,  2'b00, 1'b1, {16{8'h01}}, {16{8'h01}}, {4{32'h7FFFFFFF}}, {4{32'h7FFFFFFF}}},
    // R6: signed clamp low
    '{4'd6,  2'b00, 1'b1, {16{8'h01}}, {16{8'hFF}}, {4{32'h80000000}}, {4{32'h80000000}}},
    // R7: unsigned clamp at ceiling
    '{4'd7,  2'b10, 1'b1, {16{8'hFF}}, {16{8'hFF}}, {4{32'hFFFFFF00}}, {4{32'hFFFFFFFF}}},
    // R5: unsigned wrap past 2^32
    '{4'd5,  2'b10, 1'b0, {16{8'hFF}}, {16{8'hFF}}, {4{32'hFFFFFF00}}, {4{32'h0003F704}}},
    // R7: accumulator read unsigned, no clamp at 2^31
    '{4'd7,  2'b10, 1'b1, {16{8'h01}}, {16{8'h01}}, {4{32'h7FFFFFFF}}, {4{32'h80000003}}},
    // R6: mixed-mode clamp low
    '{4'd6,  2'b01, 1'b1, {16{8'h80}}, {16{8'hFF}}, {4{32'h80000000}}, {4{32'h80000000}}},
    // R6: mixed-mode clamp high
    '{4'd6,  2'b01, 1'b1, {16{8'h7F}}, {16{8'hFF}}, {4{32'h7FFFFFF0}}, {4{32'h7FFFFFFF}}},
    // R10: code 11 behaves as both signed
    '{4'd10, 2'b11, 1'b0, {16{8'hFF}}, {16{8'hFF}}, {4{32'd0}}, {4{32'h00000004}}},
    // R1: distinct lanes
    '{4'd1,  2'b00, 1'b0, 128'h04040404_03030303_02020202_01010101, {16{8'h01}},
             {32'd3, 32'd2, 32'd1, 32'd0}, {32'h13, 32'h0E, 32'h09, 32'h04}},
    // R1: byte positions inside a lane
    '{4'd1,  2'b00, 1'b0, {4{32'h7F000005}}, {4{32'h01000001}}, {4{32'd0}}, {4{32'h00000084}}}
  };

  logic         clk, rst_n, in_vld, sat_en;
  logic [1:0]   sgn_sel;
  logic [W-1:0] opa, opb, acc_in, out_data;
  logic         out_vld;
  int           total, bad;

  pbdp_acc #(.LANES(L)) dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .sgn_sel(sgn_sel), .sat_en(sat_en),
    .opa(opa), .opb(opb), .acc_in(acc_in), .out_vld(out_vld), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Reference arithmetic written from the requirements
  function automatic logic [W-1:0] model(input logic [1:0] sel, input logic sat,
                                         input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [W-1:0] acc);
    logic [W-1:0] r;
    bit as, bs, us;
    as = (sel != 2'b10);
    bs = (sel == 2'b00) || (sel == 2'b11);
    us = (sel == 2'b10);
    for (int j = 0; j < L; j++) begin
      longint s, av, bv;
      s = us ? longint'(acc[j*32 +: 32]) : longint'($signed(acc[j*32 +: 32]));
      for (int k = 0; k < 4; k++) begin
        av = longint'(a[(4*j+k)*8 +: 8]);
        bv = longint'(b[(4*j+k)*8 +: 8]);
        if (as && av > 127) av = av - 256;
        if (bs && bv > 127) bv = bv - 256;
        s = s + av * bv;
      end
      if (sat && us && s > 64'sd4294967295) s = 64'sd4294967295;
      if (sat && !us && s > 64'sd2147483647) s = 64'sd2147483647;
      if (sat && !us && s < -64'sd2147483648) s = -64'sd2147483648;
      r[j*32 +: 32] = s[31:0];
    end
    return r;
  endfunction

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] last;
    total = 0; bad = 0;
    rst_n = 1'b0; in_vld = 1'b0; sgn_sel = 2'b00; sat_en = 1'b0;
    opa = '0; opb = '0; acc_in = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 data", out_data, '0);
    chk("R9 vld", {{(W-1){1'b0}}, out_vld}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table walked back to back: check entry i-1 while driving entry i
    for (int i = 0; i <= NV; i++) begin
      if (i > 0) begin
        chk($sformatf("R%0d vec%0d", TBL[i-1].req, i-1), out_data, TBL[i-1].exp);
        chk("R8 vld", {{(W-1){1'b0}}, out_vld}, {{(W-1){1'b0}}, 1'b1});
      end
      if (i < NV) begin
        in_vld = 1'b1; sgn_sel = TBL[i].sel; sat_en = TBL[i].sat;
        opa = TBL[i].a; opb = TBL[i].b; acc_in = TBL[i].acc;
      end else begin
        in_vld = 1'b0;
      end
      @(negedge clk);
    end

    // R8: hold with changing inputs and no strobe
    last = TBL[NV-1].exp;
    for (int i = 0; i < 3; i++) begin
      opa = {4{$urandom}}; opb = {4{$urandom}}; acc_in = {4{$urandom}};
      sgn_sel = 2'(i);
      @(negedge clk);
      chk("R8 hold", out_data, last);
      chk("R8 idle vld", {{(W-1){1'b0}}, out_vld}, '0);
    end

    // R5 R6 R7: mixed patterns against the reference arithmetic
    for (int i = 0; i < 48; i++) begin
      logic [1:0] s;
      logic       t;
      s = 2'(i % 4);
      t = 1'((i / 4) % 2);
      in_vld = 1'b1; sgn_sel = s; sat_en = t;
      opa = {$urandom, $urandom, $urandom, $urandom};
      opb = {$urandom, $urandom, $urandom, $urandom};
      acc_in = (i % 3 == 0) ? {4{32'h7FFFF000}} :
               (i % 3 == 1) ? {4{32'h80000800}} : {$urandom, $urandom, $urandom, $urandom};
      @(negedge clk);
      in_vld = 1'b0;
      chk($sformatf("R%0d mix%0d", t ? (s == 2'b10 ? 7 : 6) : 5, i),
          out_data, model(s, t, opa, opb, acc_in));
    end

    // R9: mid-run reset clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 mid data", out_data, '0);
    chk("R9 mid vld", {{(W-1){1'b0}}, out_vld}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule